// File: doc/BRIEF.md
# Four-Way Processor-to-Memory Crossbar Switch

This block joins a set of processor request ports to an equal set of memory module ports through a full matrix of switch points. Each processor offers one transfer at a time: a request strobe, a write flag, an address and write data. The top bits of the address name the target module. The switch point at every processor and module crossing looks at that address and raises a request towards its own module only.

Every module has its own arbiter with a fixed order. Processor 0 comes first and the last processor comes last. The winner's word index, write flag and write data go to the module in the same cycle, and the winner sees `p_ready` high. A processor that loses keeps its request stable and waits with `p_ready` low. Processors that name different modules all proceed in the same cycle.

One cycle after a grant, the winner alone sees `p_ack` high, and `p_rdata` carries the word the module returned. The modules are synchronous register arrays outside the block. Each one takes the strobe, index, write flag and data at a clock edge and presents its read word after that edge.

Top module: `xbar_switch`

## Requirements
- R1: The module is picked by the two most significant address bits (address 8'h3F goes to module 0, 8'h40 to module 1). The remaining six low bits go unchanged onto that module's `m_addr`.
- R2: Requests that name distinct modules are all granted (`p_ready` high) in the same cycle.
- R3: No module ever has more than one processor granted in a cycle.
- R4: When several processors name one module, the lowest-numbered one wins. The order never rotates: a lower-numbered processor that keeps contending keeps winning.
- R5: A denied processor sees `p_ready` low. It is granted in the first cycle in which no lower-numbered processor requests its module.
- R6: `p_ack` rises for exactly the processors granted in the previous cycle. In that cycle `p_rdata` equals the target module's `m_rdata`. Otherwise `p_rdata` is zero.
- R7: A granted write puts the winner's write flag and write data on its module. A module with no requester keeps `m_en` low.
- R8: While `rst_n` is low and after its release, `p_ack` is low and `p_rdata` is zero until a grant happens.
- R9: A processor with `p_req` low gets no grant, and its address has no effect on any module.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p_req | input | NP | Per-processor request strobe |
| p_we | input | NP | Per-processor write flag |
| p_addr | input | NP x AW | Per-processor address, top MW bits select the module |
| p_wdata | input | NP x DW | Per-processor write data |
| p_ready | output | NP | Grant this cycle; low means stalled |
| p_ack | output | NP | Transfer completed, one cycle after the grant |
| p_rdata | output | NP x DW | Read word, valid with p_ack, zero otherwise |
| m_en | output | NM | Per-module access strobe |
| m_we | output | NM | Per-module write flag |
| m_addr | output | NM x IW | Per-module word index |
| m_wdata | output | NM x DW | Per-module write data |
| m_rdata | input | NM x DW | Per-module read word, registered in the module |

## Verification
Several rules are checked by properties on every cycle:
- a single grant per module;
- no grant without a request;
- the winner is never outranked by a lower-numbered requester;
- an uncontested request always goes through;
- an acknowledge appears exactly one cycle after a grant;
- every module strobe and write traces back to a granted processor.

Other behaviour only the bench scenarios can show:
- that data actually lands at the right word of the right module and comes back to the right processor;
- that a stalled request completes later with its original contents;
- that the priority order stays fixed across repeated contention.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Module number held in the top msel_w bits of an aw-bit address.
  function automatic logic [31:0] mod_sel(input logic [31:0] addr, input int aw, input int msel_w);
    return (addr >> (aw - msel_w)) & ((32'd1 << msel_w) - 32'd1);
  endfunction

  // Word index inside a module: the address with its select bits removed.
  function automatic logic [31:0] word_idx(input logic [31:0] addr, input int aw, input int msel_w);
    return addr & ((32'd1 << (aw - msel_w)) - 32'd1);
  endfunction

  // Isolates the lowest set bit (fixed priority, bit 0 first).
  function automatic logic [31:0] pick_lowest(input logic [31:0] r);
    return r & (~r + 32'd1);
  endfunction

endpackage

// File: rtl/xbar_decode.sv
module xbar_decode #(
  parameter int AW = 8,
  parameter int NM = 4,
  localparam int MW = $clog2(NM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  output logic [NM-1:0] hit
);

  for (genvar m = 0; m < NM; m++) begin : g_pt
    assign hit[m] = req && (xbar_pkg::mod_sel(32'(addr), AW, MW) == 32'(m));
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $countones(hit) == 1); // R1
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> hit == '0); // R9

endmodule

// File: rtl/xbar_arbiter.sv
module xbar_arbiter #(
  parameter int NP = 4,
  localparam int PW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] col_req,
  output logic [NP-1:0] gnt,
  output logic [PW-1:0] win,
  output logic          busy
);

  assign gnt  = NP'(xbar_pkg::pick_lowest(32'(col_req)));
  assign busy = |col_req;

  always_comb begin
    win = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (col_req[i]) win = PW'(i);
    end
  end

  for (genvar k = 0; k < NP; k++) begin : g_prio
    localparam logic [NP-1:0] ABOVE = NP'((32'd1 << k) - 32'd1);
    AST_FIXED_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[k] |-> ((col_req & ABOVE) == '0)); // R4
    AST_WIN_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[k] |-> win == PW'(k)); // R4
  end

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~col_req) == '0); // R9

endmodule

// File: rtl/xbar_return.sv
module xbar_return #(
  parameter int NP = 4,
  parameter int NM = 4,
  parameter int DW = 16,
  localparam int MW = $clog2(NM)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          ready,
  input  logic [NP-1:0][MW-1:0]  tgt,
  input  logic [NM-1:0][DW-1:0]  m_rdata,
  output logic [NP-1:0]          ack,
  output logic [NP-1:0][DW-1:0]  rdata
);

  logic [NP-1:0]         ack_q;
  logic [NP-1:0][MW-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= '0;
      tgt_q <= '0;
    end else begin
      ack_q <= ready;
      for (int p = 0; p < NP; p++) begin
        if (ready[p]) tgt_q[p] <= tgt[p];
      end
    end
  end

  assign ack = ack_q;

  for (genvar p = 0; p < NP; p++) begin : g_ret
    assign rdata[p] = ack_q[p] ? m_rdata[tgt_q[p]] : '0;

    AST_ACK_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      ready[p] |=> ack[p]); // R6
    AST_ACK_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      !ready[p] |=> !ack[p]); // R6
  end

endmodule

// File: rtl/xbar_switch.sv
module xbar_switch #(
  parameter int NP = 4,
  parameter int NM = 4,
  parameter int AW = 8,
  parameter int DW = 16,
  localparam int MW = $clog2(NM),
  localparam int PW = $clog2(NP),
  localparam int IW = AW - MW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NP-1:0]         p_req,
  input  logic [NP-1:0]         p_we,
  input  logic [NP-1:0][AW-1:0] p_addr,
  input  logic [NP-1:0][DW-1:0] p_wdata,
  output logic [NP-1:0]         p_ready,
  output logic [NP-1:0]         p_ack,
  output logic [NP-1:0][DW-1:0] p_rdata,
  output logic [NM-1:0]         m_en,
  output logic [NM-1:0]         m_we,
  output logic [NM-1:0][IW-1:0] m_addr,
  output logic [NM-1:0][DW-1:0] m_wdata,
  input  logic [NM-1:0][DW-1:0] m_rdata
);

  logic [NP-1:0][NM-1:0] hit;      // switch point p,m requests module m
  logic [NM-1:0][NP-1:0] col_req;  // same matrix seen from each module
  logic [NM-1:0][NP-1:0] gnt;
  logic [NM-1:0][PW-1:0] win;
  logic [NM-1:0]         busy;
  logic [NP-1:0][MW-1:0] tgt;

  for (genvar p = 0; p < NP; p++) begin : g_row
    xbar_decode #(.AW(AW), .NM(NM)) u_dec (
      .clk (clk), .rst_n (rst_n), .req (p_req[p]), .addr (p_addr[p]), .hit (hit[p])
    );
    assign tgt[p] = MW'(xbar_pkg::mod_sel(32'(p_addr[p]), AW, MW));
  end

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      for (int p = 0; p < NP; p++) col_req[m][p] = hit[p][m];
    end
  end

  for (genvar m = 0; m < NM; m++) begin : g_col
    xbar_arbiter #(.NP(NP)) u_arb (
      .clk (clk), .rst_n (rst_n), .col_req (col_req[m]),
      .gnt (gnt[m]), .win (win[m]), .busy (busy[m])
    );

    assign m_en[m]    = busy[m];
    assign m_we[m]    = busy[m] & p_we[win[m]];
    assign m_addr[m]  = busy[m] ? IW'(xbar_pkg::word_idx(32'(p_addr[win[m]]), AW, MW)) : '0;
    assign m_wdata[m] = busy[m] ? p_wdata[win[m]] : '0;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(p_ready & col_req[m]) <= 1); // R3
    AST_EN_TRACES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      m_en[m] |-> (p_ready & col_req[m]) != '0); // R7
    AST_WRITE_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
      m_we[m] |-> (p_ready & p_we & col_req[m]) != '0); // R7
  end

  always_comb begin
    p_ready = '0;
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < NM; m++) p_ready[p] = p_ready[p] | gnt[m][p];
    end
  end

  xbar_return #(.NP(NP), .NM(NM), .DW(DW)) u_ret (
    .clk (clk), .rst_n (rst_n), .ready (p_ready), .tgt (tgt),
    .m_rdata (m_rdata), .ack (p_ack), .rdata (p_rdata)
  );

  for (genvar p = 0; p < NP; p++) begin : g_chk
    localparam logic [NP-1:0] ABOVE = NP'((32'd1 << p) - 32'd1);
    AST_UNCONTESTED_GOES: assert property (@(posedge clk) disable iff (!rst_n)
      (p_req[p] && (col_req[tgt[p]] & ABOVE) == '0) |-> p_ready[p]); // R2
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (p_req == '0) |-> (m_en == '0)); // R7

endmodule

// File: tb/tb_xbar_switch.sv
`timescale 1ns/1ps
module tb_xbar_switch;
  localparam int NP = 4, NM = 4, AW = 8, DW = 16, MW = 2, IW = 6, NV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NP-1:0]         p_req, p_we, p_ready, p_ack;
  logic [NP-1:0][AW-1:0] p_addr;
  logic [NP-1:0][DW-1:0] p_wdata, p_rdata;
  logic [NM-1:0]         m_en, m_we;
  logic [NM-1:0][IW-1:0] m_addr;
  logic [NM-1:0][DW-1:0] m_wdata, mrd;

  xbar_switch #(.NP(NP), .NM(NM), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_we(p_we), .p_addr(p_addr),
    .p_wdata(p_wdata), .p_ready(p_ready), .p_ack(p_ack), .p_rdata(p_rdata),
    .m_en(m_en), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(mrd)
  );

  function automatic logic [DW-1:0] init_word(input int m, input int w);
    return 16'hA000 ^ 16'(m << 8) ^ 16'(w);
  endfunction

  // Behavioural memory modules: read returns the old word.
  logic [DW-1:0] mem [NM][1<<IW];
  always_ff @(posedge clk) begin
    for (int m = 0; m < NM; m++) begin
      if (!rst_n) begin
        for (int w = 0; w < (1 << IW); w++) mem[m][w] <= init_word(m, w);
        mrd[m] <= '0;
      end else if (m_en[m]) begin
        mrd[m] <= mem[m][m_addr[m]];
        if (m_we[m]) mem[m][m_addr[m]] <= m_wdata[m];
      end
    end
  end

  // Vector table; bit p / byte p belongs to processor p.
  localparam logic [3:0] V_REQ [NV] = '{4'b0000, 4'b1111, 4'b1111, 4'b1110, 4'b1111,
                                        4'b1000, 4'b1011, 4'b1010, 4'b1111, 4'b1000};
  localparam logic [3:0] V_WE  [NV] = '{4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b0011,
                                        4'b0000, 4'b0000, 4'b1000, 4'b0100, 4'b0000};
  localparam logic [31:0] V_ADDR [NV] = '{32'hC0804000, 32'hC38A4705, 32'h84838281,
                                          32'h52515000, 32'hC6C54B0A, 32'h81000000,
                                          32'hC7C00505, 32'h10008200, 32'h47470510,
                                          32'h47000000};
  localparam logic [3:0] V_RDY [NV] = '{4'b0000, 4'b1111, 4'b0001, 4'b0010, 4'b0111,
                                        4'b1000, 4'b1001, 4'b1010, 4'b0101, 4'b1000};

  int total = 0;
  int bad = 0;
  logic [DW-1:0] shadow [1<<AW];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    p_req = '0; p_we = '0; p_addr = '0; p_wdata = '0;
  endtask

  task automatic put(input int p, input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    p_req[p] = 1'b1; p_we[p] = we; p_addr[p] = a; p_wdata[p] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NP-1:0][DW-1:0] exp_rd;
    logic [NM-1:0] exp_en;
    for (int a = 0; a < (1 << AW); a++) shadow[a] = init_word(a >> IW, a % (1 << IW));

    // R8: requests offered during reset produce no acknowledge.
    idle_all();
    for (int p = 0; p < NP; p++) put(p, 1'b0, AW'(p * 64 + 1), '0);
    repeat (3) @(posedge clk);
    #1;
    chk(p_ack == '0, "R8 ack in reset", 32'(p_ack), 0);
    chk(p_rdata == '0, "R8 rdata in reset", 32'(p_rdata[0]), 0);
    @(negedge clk);
    idle_all();
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(p_ack == '0, "R8 ack after reset", 32'(p_ack), 0);
    chk(p_rdata == '0, "R8 rdata after reset", 32'(p_rdata[1]), 0);

    // Table walk: R2 R3 R4 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        p_req[p] = V_REQ[v][p];
        p_we[p] = V_WE[v][p];
        p_addr[p] = V_ADDR[v][8*p +: 8];
        p_wdata[p] = 16'h5000 | 16'(v << 4) | 16'(p);
      end
      #1;
      chk(p_ready == V_RDY[v], "R4 R3 R2 R9 ready pattern", 32'(p_ready), 32'(V_RDY[v]));
      exp_en = '0;
      exp_rd = '0;
      for (int p = 0; p < NP; p++) begin
        if (V_RDY[v][p]) begin
          exp_en[p_addr[p] >> IW] = 1'b1;
          exp_rd[p] = shadow[p_addr[p]];
          if (p_we[p]) shadow[p_addr[p]] = p_wdata[p];
        end
      end
      chk(m_en == exp_en, "R7 module strobes", 32'(m_en), 32'(exp_en));
      @(posedge clk); #1;
      chk(p_ack == V_RDY[v], "R6 ack follows grant", 32'(p_ack), 32'(V_RDY[v]));
      for (int p = 0; p < NP; p++)
        chk(p_rdata[p] == exp_rd[p], "R6 R1 returned word", 32'(p_rdata[p]), 32'(exp_rd[p]));
    end

    // R5: stalled write completes later with its data intact.
    @(negedge clk); idle_all();
    put(0, 1'b1, 8'h60, 16'h1111);
    put(1, 1'b1, 8'h61, 16'h2222);
    #1;
    chk(p_ready == 4'b0001, "R5 p1 stalled", 32'(p_ready), 32'h1);
    @(negedge clk);
    p_req[0] = 1'b0;
    #1;
    chk(p_ready == 4'b0010, "R5 p1 granted after p0 leaves", 32'(p_ready), 32'h2);
    @(posedge clk); #1;
    chk(p_ack == 4'b0010, "R5 p1 ack", 32'(p_ack), 32'h2);
    @(negedge clk); idle_all();
    put(1, 1'b0, 8'h61, '0);
    @(posedge clk); #1;
    chk(p_rdata[1] == 16'h2222, "R5 stalled write landed", 32'(p_rdata[1]), 32'h2222);
    @(negedge clk); idle_all();
    put(3, 1'b0, 8'h60, '0);
    @(posedge clk); #1;
    chk(p_rdata[3] == 16'h1111, "R7 p0 write landed", 32'(p_rdata[3]), 32'h1111);

    // R4: priority does not rotate under repeated contention.
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); idle_all();
      put(0, 1'b0, AW'(8'hC1 + c), '0);
      put(2, 1'b0, 8'hC9, '0);
      #1;
      chk(p_ready == 4'b0001, "R4 p0 keeps winning", 32'(p_ready), 32'h1);
    end
    @(negedge clk);
    p_req[0] = 1'b0;
    #1;
    chk(p_ready == 4'b0100, "R5 p2 granted once free", 32'(p_ready), 32'h4);
    @(posedge clk); #1;
    chk(p_rdata[2] == init_word(3, 9), "R6 p2 read word", 32'(p_rdata[2]), 32'(init_word(3, 9)));

    // R1: boundary between module 0 and module 1.
    @(negedge clk); idle_all();
    put(0, 1'b0, 8'h3F, '0);
    put(1, 1'b0, 8'h40, '0);
    #1;
    chk(p_ready == 4'b0011, "R1 boundary both granted", 32'(p_ready), 32'h3);
    chk(m_en == 4'b0011, "R1 boundary strobes", 32'(m_en), 32'h3);
    chk(m_addr[0] == 6'd63, "R1 index module0", 32'(m_addr[0]), 32'd63);
    chk(m_addr[1] == 6'd0, "R1 index module1", 32'(m_addr[1]), 32'd0);
    @(posedge clk); #1;
    chk(p_rdata[0] == init_word(0, 63), "R1 word from module0", 32'(p_rdata[0]), 32'(init_word(0, 63)));
    chk(p_rdata[1] == init_word(1, 0), "R1 word from module1", 32'(p_rdata[1]), 32'(init_word(1, 0)));
    @(negedge clk); idle_all();
    #1;
    chk(m_en == '0, "R7 idle modules quiet", 32'(m_en), 0);
    @(posedge clk); #1;
    chk(p_ack == '0 && p_rdata == '0, "R6 no ack when idle", 32'(p_ack), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule